// File: doc/BRIEF.md
# LED Driver Fault Classifier

This block sits between a PWM source and a linear LED driver. That kind of driver reports every fault on one shared active-low line, so the line alone does not say which fault happened. The block also watches a comparator that goes high when the driver output rises above a trip voltage. When a fault appears it takes over the PWM line and forces it low, then checks how the two inputs respond. From that it tells apart four faults: open load, short to battery, short to ground and overtemperature.

Both inputs are resynchronised and must agree on two consecutive samples before anything happens. A fault that pulls the output high (comparator high) is resolved after a short settle delay with PWM forced low. A fault with the comparator low is resolved after a much longer cooling interval, again with PWM forced low. The result is held on a three-bit code and announced by a one-cycle valid pulse. For faults that can damage the driver, PWM stays forced low until software clears the code. Both intervals are parameters counted in clock cycles.

Top module: `led_fault_classifier`

## Requirements
- R1: After reset `fault_code` is 3'b000, `code_valid` is 0 and `busy` is 0. While the block is monitoring, `pwm_out` equals `pwm_req` in the same cycle.
- R2: Both inputs pass through two synchroniser flops. Classification starts only when `fault_n_in` low, with the same `vcomp_in` level, is seen on two consecutive synchronised samples. An input pattern applied before rising edge 1 makes `busy` high after rising edge 4. A one-cycle low pulse on `fault_n_in` never starts classification.
- R3: A confirmed (`fault_n_in`=0, `vcomp_in`=1) starts a settle interval of SETTLE_CYC cycles. If (0,1) is still seen at its end, the code is 3'b010 (short to battery).
- R4: If (`fault_n_in`=1, `vcomp_in`=0) is seen at the end of the settle interval, the code is 3'b001 (open load), and `pwm_out` follows `pwm_req` again.
- R5: A confirmed (`fault_n_in`=0, `vcomp_in`=0) starts a cooling interval of COOL_CYC cycles. If `fault_n_in` is still low at its end, the code is 3'b011 (short to ground).
- R6: If `fault_n_in` has returned high by the end of the cooling interval, the code is 3'b100 (overtemperature), PWM passes through again, and a later trip is classified afresh.
- R7: A comparator that goes high while `fault_n_in` is still high (the driver's deglitch gap) causes no action. When `fault_n_in` then falls, the fault is classified as in R3.
- R8: Any other pattern at the end of the settle interval, for example (1,1), returns the block to monitoring. No code is latched and no valid pulse is issued.
- R9: `code_valid` pulses for exactly one cycle in the cycle after the interval ends. `fault_code` then holds until `clear` is sampled high, after which it reads 3'b000.
- R10: After short to battery or short to ground, `pwm_out` stays low whatever `pwm_req` does, until `clear` is sampled high. From the next cycle `pwm_out` follows `pwm_req` again.
- R11: `busy` is high exactly while an interval runs: SETTLE_CYC cycles for a comparator-high fault, COOL_CYC cycles for a comparator-low fault. `pwm_out` is low during that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 1 | PWM requested by the dimming source |
| fault_n_in | input | 1 | Driver shared fault line, active low, asynchronous |
| vcomp_in | input | 1 | Output over-voltage comparator, high above trip, asynchronous |
| clear | input | 1 | Clears the held code and releases a PWM lock |
| pwm_out | output | 1 | Gated PWM to the driver |
| fault_code | output | 3 | Held fault classification |
| code_valid | output | 1 | One-cycle pulse when a new code is latched |
| busy | output | 1 | High while a settle or cooling interval runs |

## Verification
The bench goes after the timing edges where a faulty design would misclassify. If the confirm stage were missing, a one-cycle fault pulse would start an interval. An off-by-one timer would give a `busy` window one cycle short or long of SETTLE_CYC or COOL_CYC. Sampling too early in the settle interval would read the unsettled open-load inputs as short to battery. It also drives the deglitch gap, where the comparator rises before the fault line falls: a design that acted on the comparator alone would leave monitoring early. Finally it checks that the short faults keep PWM gated until clear, that open load and overtemperature resume pass-through, and that an inconsistent end sample latches nothing.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic [2:0] {
    FC_NONE      = 3'd0,
    FC_OPEN      = 3'd1,
    FC_SHORT_BAT = 3'd2,
    FC_SHORT_GND = 3'd3,
    FC_OVERTEMP  = 3'd4
  } fcode_e;

  typedef enum logic [1:0] {
    ST_WATCH  = 2'd0,
    ST_SETTLE = 2'd1,
    ST_COOL   = 2'd2,
    ST_LOCK   = 2'd3
  } fsm_e;

  // Verdict at the end of the settle interval (PWM forced low).
  function automatic fcode_e settle_verdict(input logic fault_n, input logic vcomp);
    fcode_e r;
    case ({fault_n, vcomp})
      2'b01:   r = FC_SHORT_BAT;
      2'b10:   r = FC_OPEN;
      default: r = FC_NONE;
    endcase
    return r;
  endfunction

  // Verdict at the end of the cooling interval.
  function automatic fcode_e cool_verdict(input logic fault_n);
    return fault_n ? FC_OVERTEMP : FC_SHORT_GND;
  endfunction

  // Faults that keep PWM gated until software clears them.
  function automatic logic holds_gate(input fcode_e c);
    return (c == FC_SHORT_BAT) || (c == FC_SHORT_GND);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lfc_sync.sv
module lfc_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lfc_timer.sv
module lfc_timer #(
  parameter int unsigned SETTLE_CYC = 300,
  parameter int unsigned COOL_CYC   = 30_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pick_cool,
  output logic done
);
  import lfc_pkg::*;

  localparam int unsigned MAXC = max_u(SETTLE_CYC, COOL_CYC);
  localparam int          CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] LOAD_SETTLE = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] LOAD_COOL   = CW'(COOL_CYC - 1);
  localparam logic [CW-1:0] LOAD_MAX    = CW'(MAXC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= pick_cool ? LOAD_COOL : LOAD_SETTLE;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD_MAX);  // R11
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));  // R11
endmodule

// File: rtl/lfc_fsm.sv
module lfc_fsm (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_n_s,
  input  logic            vcomp_s,
  input  logic            clear,
  input  logic            tmr_done,
  output logic            tmr_start,
  output logic            tmr_pick_cool,
  output logic            confirm,
  output lfc_pkg::fsm_e   state,
  output logic            latch,
  output lfc_pkg::fcode_e latch_code
);
  import lfc_pkg::*;

  logic  fault_n_p, vcomp_p;
  fsm_e  state_nx;
  fcode_e verdict;

  // Previous synchronised sample for the two-in-a-row confirmation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_n_p <= 1'b1;
      vcomp_p   <= 1'b0;
    end else begin
      fault_n_p <= fault_n_s;
      vcomp_p   <= vcomp_s;
    end
  end

  assign confirm = !fault_n_s && !fault_n_p && (vcomp_s == vcomp_p);

  always_comb begin
    state_nx      = state;
    tmr_start     = 1'b0;
    tmr_pick_cool = 1'b0;
    latch         = 1'b0;
    latch_code    = FC_NONE;
    verdict       = FC_NONE;
    case (state)
      ST_WATCH: begin
        if (confirm) begin
          tmr_start     = 1'b1;
          tmr_pick_cool = !vcomp_s;
          state_nx      = vcomp_s ? ST_SETTLE : ST_COOL;
        end
      end
      ST_SETTLE: begin
        if (tmr_done) begin
          verdict = settle_verdict(fault_n_s, vcomp_s);
          if (verdict == FC_NONE) begin
            state_nx = ST_WATCH;
          end else begin
            latch      = 1'b1;
            latch_code = verdict;
            state_nx   = holds_gate(verdict) ? ST_LOCK : ST_WATCH;
          end
        end
      end
      ST_COOL: begin
        if (tmr_done) begin
          verdict    = cool_verdict(fault_n_s);
          latch      = 1'b1;
          latch_code = verdict;
          state_nx   = holds_gate(verdict) ? ST_LOCK : ST_WATCH;
        end
      end
      ST_LOCK: begin
        if (clear) state_nx = ST_WATCH;
      end
      default: state_nx = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WATCH;
    else        state <= state_nx;
  end

  AST_START_ENTERS_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start |=> (state == ST_SETTLE || state == ST_COOL));  // R3
  AST_COOL_FROM_LOW_VCOMP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WATCH && confirm && !vcomp_s) |=> (state == ST_COOL));  // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK && !clear) |=> (state == ST_LOCK));  // R10
endmodule

// File: rtl/lfc_report.sv
module lfc_report (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch,
  input  lfc_pkg::fcode_e latch_code,
  input  logic            clear,
  output lfc_pkg::fcode_e code_q,
  output logic            valid_q
);
  import lfc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= FC_NONE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= latch;
      if (latch)      code_q <= latch_code;
      else if (clear) code_q <= FC_NONE;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);  // R9
  AST_VALID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (code_q != FC_NONE));  // R8
endmodule

// File: rtl/led_fault_classifier.sv
module led_fault_classifier #(
  parameter int unsigned SETTLE_CYC = 300,
  parameter int unsigned COOL_CYC   = 30_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_req,
  input  logic       fault_n_in,
  input  logic       vcomp_in,
  input  logic       clear,
  output logic       pwm_out,
  output logic [2:0] fault_code,
  output logic       code_valid,
  output logic       busy
);
  import lfc_pkg::*;

  logic [1:0] raw_in, sync_out;
  logic       fault_n_s, vcomp_s;
  logic       tmr_start, tmr_pick_cool, tmr_done, confirm, latch;
  fsm_e       state;
  fcode_e     latch_code, code_q;

  assign raw_in = {fault_n_in, vcomp_in};

  lfc_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );
  assign fault_n_s = sync_out[1];
  assign vcomp_s   = sync_out[0];

  lfc_timer #(.SETTLE_CYC(SETTLE_CYC), .COOL_CYC(COOL_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .pick_cool(tmr_pick_cool), .done(tmr_done)
  );

  lfc_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .fault_n_s(fault_n_s), .vcomp_s(vcomp_s), .clear(clear),
    .tmr_done(tmr_done), .tmr_start(tmr_start), .tmr_pick_cool(tmr_pick_cool),
    .confirm(confirm), .state(state), .latch(latch), .latch_code(latch_code)
  );

  lfc_report i_report (
    .clk(clk), .rst_n(rst_n), .latch(latch), .latch_code(latch_code), .clear(clear),
    .code_q(code_q), .valid_q(code_valid)
  );

  assign pwm_out    = pwm_req && (state == ST_WATCH);
  assign busy       = (state == ST_SETTLE) || (state == ST_COOL);
  assign fault_code = code_q;

  AST_BUSY_NEEDS_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(confirm));  // R2
  AST_GATE_AFTER_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && holds_gate(latch_code)) |=> !pwm_out);  // R10
  AST_RESUME_AFTER_OT: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && latch_code == FC_OVERTEMP) |=> (pwm_out == pwm_req));  // R6
  AST_GATED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_start) |=> (busy && !pwm_out));  // R11
endmodule

// File: tb/test_led_fault_classifier.sv
module test_led_fault_classifier;
  localparam int SET  = 8;
  localparam int COOL = 64;
  localparam int K_NONE = 0, K_OL = 1, K_SB = 2, K_SG = 3, K_OT = 4, K_UNX = 5;

  logic clk = 1'b0, rst_n = 1'b0, pwm_req = 1'b0, clear = 1'b0;
  logic fault_n_in, vcomp_in, pwm_out, code_valid, busy;
  logic [2:0] fault_code;
  logic ovr_en = 1'b0, fn_ovr = 1'b1, vc_ovr = 1'b0;
  logic fn_m, vc_m;
  int   kind = K_NONE;
  int   n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  // Driver model: response of the fault line and comparator per fault kind.
  always_comb begin
    case (kind)
      K_OL:       begin fn_m = !pwm_out;  vc_m = pwm_out; end
      K_SB:       begin fn_m = 1'b0;      vc_m = 1'b1;    end
      K_SG, K_OT: begin fn_m = 1'b0;      vc_m = 1'b0;    end
      K_UNX:      begin fn_m = !pwm_out;  vc_m = 1'b1;    end
      default:    begin fn_m = 1'b1;      vc_m = 1'b0;    end
    endcase
  end
  assign fault_n_in = ovr_en ? fn_ovr : fn_m;
  assign vcomp_in   = ovr_en ? vc_ovr : vc_m;

  led_fault_classifier #(.SETTLE_CYC(SET), .COOL_CYC(COOL)) i_led_fault_classifier (
    .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .fault_n_in(fault_n_in),
    .vcomp_in(vcomp_in), .clear(clear), .pwm_out(pwm_out), .fault_code(fault_code),
    .code_valid(code_valid), .busy(busy)
  );

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // One complete fault episode: detect, time, verdict, hold, clear.
  task automatic run_case(input int k, input int exp_code, input int exp_len,
                          input bit exp_lock, input string tag);
    int lat = 0;
    int len = 0;
    @(negedge clk);
    kind = k; pwm_req = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      lat++;
      if (busy) break;
    end
    check({tag, " R2 busy latency"}, lat, 4);
    check({tag, " R11 pwm gated when busy"}, pwm_out, 0);
    pwm_req = 1'b0;
    while (busy && len < 1000) begin
      len++;
      if (k == K_OT && len == 20) kind = K_NONE;
      @(negedge clk);
    end
    check({tag, " R11 busy length"}, len, exp_len);
    check({tag, " R9 valid pulse"}, code_valid, (exp_code != 0) ? 1 : 0);
    check({tag, " code"}, fault_code, exp_code);
    @(negedge clk);
    check({tag, " R9 valid one cycle"}, code_valid, 0);
    kind = K_NONE;
    repeat (4) @(negedge clk);
    pwm_req = 1'b1;
    @(negedge clk);
    check({tag, " R10 pwm gating after verdict"}, pwm_out, exp_lock ? 0 : 1);
    check({tag, " R9 code held"}, fault_code, exp_code);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check({tag, " R9 code cleared"}, fault_code, 0);
    check({tag, " R10 pwm free after clear"}, pwm_out, 1);
    pwm_req = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset code", fault_code, 0);
    check("R1 reset valid", code_valid, 0);
    check("R1 reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 pass-through sweep over request patterns
    for (int p = 0; p < 16; p++) begin
      pwm_req = p[0] ^ p[2];
      @(negedge clk);
      check("R1 pass-through", pwm_out, pwm_req);
      check("R1 no busy", busy, 0);
    end
    pwm_req = 1'b0;

    // R2 one-cycle glitch on the fault line is ignored
    ovr_en = 1'b1; fn_ovr = 1'b0; vc_ovr = 1'b0;
    @(negedge clk);
    fn_ovr = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R2 glitch ignored", busy, 0);
    end
    ovr_en = 1'b0;

    for (int rep = 0; rep < 2; rep++) begin
      run_case(K_SB,  2, SET,  1'b1, "R3 short-bat");
      run_case(K_OL,  1, SET,  1'b0, "R4 open");
      run_case(K_SG,  3, COOL, 1'b1, "R5 short-gnd");
      run_case(K_OT,  4, COOL, 1'b0, "R6 overtemp");
      run_case(K_UNX, 0, SET,  1'b0, "R8 unexpected");
    end

    // R6 repeat trip: overtemperature again right after pass-through resumed
    run_case(K_OT, 4, COOL, 1'b0, "R6 repeat trip");

    // R7 comparator rises before the fault line falls
    pwm_req = 1'b1;
    ovr_en = 1'b1; fn_ovr = 1'b1; vc_ovr = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 gap no busy", busy, 0);
      check("R7 gap pwm passes", pwm_out, 1);
    end
    ovr_en = 1'b0;
    run_case(K_SB, 2, SET, 1'b1, "R7 after gap");

    summary();
    $finish;
  end
endmodule